// File: doc/BRIEF.md
# Asynchronous Static Memory Write Sequencer

This block turns one internal write request into the pin sequence for a single write to an asynchronous static memory bank. A requester presents a bank index, address, write data and byte enables together with `req_i`. The block takes the request only while `ready_o` is high. It stores the request and then drives one chip select, the write strobe, the byte-lane strobes, an address-valid strobe, the address and the data. All strobes are active low. When the write is over, it returns a one-cycle `done_o`.

`clk_i` runs at twice the memory clock rate, so one `clk_i` cycle is one half memory cycle, called a tick below. Each bank has its own settings, and they are captured when a request is accepted:
- the wait-state count `wr`;
- the write-strobe delay `wen`;
- lane mode, for 8-bit parts that use lane strobes in place of the write strobe;
- external-wait enable;
- address-valid enable.

If `wen` is greater than `wr`, the sequence would be illegal. In that case no strobe moves and an error is reported.

Top module: `smc_wr_seq`

## Requirements
- R1: `ready_o` is high exactly when the block is idle. A request is taken at a rising edge with `req_i` and `ready_o` both high. `req_i` is ignored while `ready_o` is low: no address change and no second transfer.
- R2: After an accepted valid request, `mem_cs_n_o[bank]` goes low in the next cycle. Without stalls it stays low for 2*wr+3 consecutive ticks (ticks 0 to 2*wr+2). All other chip selects stay high, and at most one chip select is ever low.
- R3: In wide mode (lane mode 0), `mem_we_n_o` is low on ticks 2*wen+1 through 2*wr+1. It therefore falls an odd number of half cycles after chip select and rises one tick before chip select rises. Setting wr=wen=1 instead of 0 adds two ticks to chip select and moves the write strobe two ticks later.
- R4: A request whose wen exceeds wr is accepted, but no chip select, write strobe or lane strobe goes low. In the next cycle `cfg_err_o` and `done_o` are both high for one cycle, and then the block is idle.
- R5: In lane mode 1, `mem_we_n_o` stays high and `mem_bls_n_o[i]` is low exactly on the write-strobe ticks of R3 when byte enable bit i is set. In lane mode 0, `mem_bls_n_o[i]` is low on every chip-select tick when byte enable bit i is set. Bit i covers data bits 8*i+7 down to 8*i.
- R6: With external wait enabled, the tick counter holds at every rising edge where `mem_wait_i` is high and the tick is below 2*wr+2. This stretches the transfer and delays the write strobe if it has not yet fallen. With external wait disabled, `mem_wait_i` has no effect.
- R7: With address-valid enabled, `mem_adv_n_o` is low on ticks 0 and 1 of the transfer. With it disabled, `mem_adv_n_o` stays high at all times.
- R8: `mem_addr_o` and `mem_data_o` hold the values captured at acceptance until the block is idle again. Bank settings changed after acceptance have no effect on the transfer in progress.
- R9: After the last chip-select tick, the block spends one cycle with chip select high. It then raises `done_o` for exactly one cycle and returns to idle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the memory clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Write request |
| ready_o | output | 1 | Idle, request can be taken |
| bank_i | input | BANK_W | Target bank index |
| addr_i | input | ADDR_W | Write address |
| wdata_i | input | DATA_W | Write data |
| be_i | input | BE_W | Byte enables, bit i for byte i |
| cfg_wst_wr_i | input | N_BANKS*WAIT_W | Wait-state count per bank |
| cfg_wst_wen_i | input | N_BANKS*WAIT_W | Write-strobe delay per bank |
| cfg_lane_mode_i | input | N_BANKS | 1: 8-bit lane-strobe mode |
| cfg_ext_wait_en_i | input | N_BANKS | External wait enable |
| cfg_adv_en_i | input | N_BANKS | Address-valid enable |
| mem_wait_i | input | 1 | External wait, active high |
| mem_cs_n_o | output | N_BANKS | Chip selects, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |
| mem_bls_n_o | output | BE_W | Byte-lane strobes, active low |
| mem_adv_n_o | output | 1 | Address-valid strobe, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_data_o | output | DATA_W | Memory write data |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | One-cycle pulse on a rejected configuration |

## Verification
Directed writes cover the extremes of the timing settings: wr=wen=0, wr=wen=1, wr=wen=15, and wr=15 with wen=0. Together they separate the chip-select length, which depends on wr alone, from the write-strobe offset, which depends on wen. A write with wen above wr tells the error path apart from a merely short transfer. Runs with the wait input held high before the write strobe, and runs with it toggling while external wait is disabled, separate a held-off strobe from an ignored input. A constrained random series mixes banks, byte-enable patterns, lane and address-valid modes, busy-time requests, and bank settings changed mid-transfer; this exposes wrong bank decode, lane selection and capture timing.

// File: rtl/smc_wr_pkg.sv
package smc_wr_pkg;
  localparam int unsigned WAIT_W = 4;
  localparam int unsigned TICK_W = WAIT_W + 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_HOLD,
    ST_DONE,
    ST_ERR
  } seq_state_e;

  typedef struct packed {
    logic [WAIT_W-1:0] wst_wr;
    logic [WAIT_W-1:0] wst_wen;
    logic              lane_mode;
    logic              ext_wait_en;
    logic              adv_en;
  } bank_cfg_t;
endpackage

// File: rtl/smc_wr_cfg_sel.sv
module smc_wr_cfg_sel
  import smc_wr_pkg::*;
#(
  parameter int unsigned N_BANKS = 4,
  parameter int unsigned BANK_W  = 2
) (
  input  logic [BANK_W-1:0]         bank_i,
  input  logic [N_BANKS*WAIT_W-1:0] wst_wr_i,
  input  logic [N_BANKS*WAIT_W-1:0] wst_wen_i,
  input  logic [N_BANKS-1:0]        lane_mode_i,
  input  logic [N_BANKS-1:0]        ext_wait_en_i,
  input  logic [N_BANKS-1:0]        adv_en_i,
  output bank_cfg_t                 cfg_o,
  output logic                      cfg_ok_o
);
  bank_cfg_t cfg_arr [N_BANKS];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign cfg_arr[b].wst_wr      = wst_wr_i[b*WAIT_W +: WAIT_W];
    assign cfg_arr[b].wst_wen     = wst_wen_i[b*WAIT_W +: WAIT_W];
    assign cfg_arr[b].lane_mode   = lane_mode_i[b];
    assign cfg_arr[b].ext_wait_en = ext_wait_en_i[b];
    assign cfg_arr[b].adv_en      = adv_en_i[b];
  end

  assign cfg_o    = cfg_arr[bank_i];
  // strobe delay beyond the wait count would be an illegal sequence
  assign cfg_ok_o = (cfg_o.wst_wen <= cfg_o.wst_wr);
endmodule

// File: rtl/smc_wr_timer.sv
module smc_wr_timer
  import smc_wr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              stall_i,
  input  logic [WAIT_W-1:0] wst_wr_i,
  input  logic [WAIT_W-1:0] wst_wen_i,
  output logic              last_o,
  output logic              we_win_o,
  output logic              adv_win_o
);
  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] last_t, we_lo_t, we_hi_t;

  assign last_t  = {1'b0, wst_wr_i, 1'b0} + TICK_W'(2);
  assign we_lo_t = {1'b0, wst_wen_i, 1'b0} + TICK_W'(1);
  assign we_hi_t = {1'b0, wst_wr_i, 1'b0} + TICK_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             tick_q <= '0;
    else if (!run_i)                         tick_q <= '0;
    else if (!last_o && !stall_i)            tick_q <= tick_q + TICK_W'(1);
  end

  assign last_o    = run_i && (tick_q == last_t);
  assign we_win_o  = run_i && (tick_q >= we_lo_t) && (tick_q <= we_hi_t);
  assign adv_win_o = run_i && (tick_q < TICK_W'(2));
endmodule

// File: rtl/smc_wr_pins.sv
module smc_wr_pins #(
  parameter int unsigned N_BANKS = 4,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned BE_W    = 4
) (
  input  logic              active_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              we_win_i,
  input  logic              adv_win_i,
  input  logic              lane_mode_i,
  input  logic              adv_en_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [N_BANKS-1:0] cs_n_o,
  output logic              we_n_o,
  output logic [BE_W-1:0]   bls_n_o,
  output logic              adv_n_o
);
  for (genvar b = 0; b < N_BANKS; b++) begin : g_cs
    assign cs_n_o[b] = ~(active_i && (bank_i == BANK_W'(b)));
  end

  // lane mode: lane strobes take the write-strobe window
  for (genvar i = 0; i < BE_W; i++) begin : g_bls
    assign bls_n_o[i] = ~(active_i && be_i[i] && (lane_mode_i ? we_win_i : 1'b1));
  end

  assign we_n_o  = ~(active_i && we_win_i && !lane_mode_i);
  assign adv_n_o = ~(adv_en_i && adv_win_i);
endmodule

// File: rtl/smc_wr_seq.sv
module smc_wr_seq
  import smc_wr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_BANKS = 4,
  localparam int unsigned BE_W   = DATA_W / 8,
  localparam int unsigned BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  output logic                      ready_o,
  input  logic [BANK_W-1:0]         bank_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic [BE_W-1:0]           be_i,
  input  logic [N_BANKS*WAIT_W-1:0] cfg_wst_wr_i,
  input  logic [N_BANKS*WAIT_W-1:0] cfg_wst_wen_i,
  input  logic [N_BANKS-1:0]        cfg_lane_mode_i,
  input  logic [N_BANKS-1:0]        cfg_ext_wait_en_i,
  input  logic [N_BANKS-1:0]        cfg_adv_en_i,
  input  logic                      mem_wait_i,
  output logic [N_BANKS-1:0]        mem_cs_n_o,
  output logic                      mem_we_n_o,
  output logic [BE_W-1:0]           mem_bls_n_o,
  output logic                      mem_adv_n_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [DATA_W-1:0]         mem_data_o,
  output logic                      done_o,
  output logic                      cfg_err_o
);
  seq_state_e        state_q, state_d;
  bank_cfg_t         cfg_sel, cfg_q;
  logic              cfg_ok;
  logic              accept, run, last, we_win, adv_win, stall;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BE_W-1:0]   be_q;

  smc_wr_cfg_sel #(.N_BANKS(N_BANKS), .BANK_W(BANK_W)) u_cfg (
    .bank_i        (bank_i),
    .wst_wr_i      (cfg_wst_wr_i),
    .wst_wen_i     (cfg_wst_wen_i),
    .lane_mode_i   (cfg_lane_mode_i),
    .ext_wait_en_i (cfg_ext_wait_en_i),
    .adv_en_i      (cfg_adv_en_i),
    .cfg_o         (cfg_sel),
    .cfg_ok_o      (cfg_ok)
  );

  assign ready_o = (state_q == ST_IDLE);
  assign accept  = ready_o && req_i;
  assign run     = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = cfg_ok ? ST_RUN : ST_ERR;
      ST_RUN:  if (last)  state_d = ST_HOLD;
      ST_HOLD:            state_d = ST_DONE;
      ST_DONE:            state_d = ST_IDLE;
      ST_ERR:             state_d = ST_IDLE;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // request and bank settings captured once, held for the whole transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      bank_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (accept && cfg_ok) begin
      cfg_q  <= cfg_sel;
      bank_q <= bank_i;
      addr_q <= addr_i;
      data_q <= wdata_i;
      be_q   <= be_i;
    end
  end

  assign stall = cfg_q.ext_wait_en && mem_wait_i;

  smc_wr_timer u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .stall_i   (stall),
    .wst_wr_i  (cfg_q.wst_wr),
    .wst_wen_i (cfg_q.wst_wen),
    .last_o    (last),
    .we_win_o  (we_win),
    .adv_win_o (adv_win)
  );

  smc_wr_pins #(.N_BANKS(N_BANKS), .BANK_W(BANK_W), .BE_W(BE_W)) u_pins (
    .active_i    (run),
    .bank_i      (bank_q),
    .we_win_i    (we_win),
    .adv_win_i   (adv_win),
    .lane_mode_i (cfg_q.lane_mode),
    .adv_en_i    (cfg_q.adv_en),
    .be_i        (be_q),
    .cs_n_o      (mem_cs_n_o),
    .we_n_o      (mem_we_n_o),
    .bls_n_o     (mem_bls_n_o),
    .adv_n_o     (mem_adv_n_o)
  );

  assign mem_addr_o = addr_q;
  assign mem_data_o = data_q;
  assign done_o     = (state_q == ST_DONE) || (state_q == ST_ERR);
  assign cfg_err_o  = (state_q == ST_ERR);
endmodule

// File: rtl/smc_wr_seq_chk.sv
module smc_wr_seq_chk #(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_BANKS = 4,
  parameter int unsigned BE_W    = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ready_o,
  input logic [N_BANKS-1:0] mem_cs_n_o,
  input logic               mem_we_n_o,
  input logic [BE_W-1:0]    mem_bls_n_o,
  input logic               mem_adv_n_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic [DATA_W-1:0]  mem_data_o,
  input logic               done_o,
  input logic               cfg_err_o
);
  logic cs_any;
  assign cs_any = (mem_cs_n_o != '1);

  assert_ready_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !cs_any);

  assert_cs_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~mem_cs_n_o) <= 1);

  assert_we_inside_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> cs_any);

  assert_we_rise_before_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> cs_any);

  assert_err_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (done_o && !cs_any && mem_bls_n_o == '1));

  assert_bls_inside_cs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_bls_n_o != '1) |-> cs_any);

  assert_adv_inside_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_adv_n_o |-> cs_any);

  assert_bus_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_any && $past(cs_any)) |-> ($stable(mem_addr_o) && $stable(mem_data_o)));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_any);
endmodule

bind smc_wr_seq smc_wr_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_BANKS(N_BANKS), .BE_W(BE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .mem_cs_n_o  (mem_cs_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_bls_n_o (mem_bls_n_o),
  .mem_adv_n_o (mem_adv_n_o),
  .mem_addr_o  (mem_addr_o),
  .mem_data_o  (mem_data_o),
  .done_o      (done_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/tb_smc_wr_seq.sv
module tb_smc_wr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          ready;
  logic [1:0]    bank = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [BW-1:0] be = '0;
  logic [NB*4-1:0] c_wr = '0, c_wen = '0;
  logic [NB-1:0] c_lane = '0, c_ext = '0, c_adv = '1;
  logic          mwait = 1'b0;
  logic [NB-1:0] cs_n;
  logic          we_n, adv_n, done, err;
  logic [BW-1:0] bls_n;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mdata;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smc_wr_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_o(ready),
    .bank_i(bank), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .cfg_wst_wr_i(c_wr), .cfg_wst_wen_i(c_wen), .cfg_lane_mode_i(c_lane),
    .cfg_ext_wait_en_i(c_ext), .cfg_adv_en_i(c_adv), .mem_wait_i(mwait),
    .mem_cs_n_o(cs_n), .mem_we_n_o(we_n), .mem_bls_n_o(bls_n),
    .mem_adv_n_o(adv_n), .mem_addr_o(maddr), .mem_data_o(mdata),
    .done_o(done), .cfg_err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [BW-1:0] exp_bls(input logic [BW-1:0] b, input bit lane, input bit wwin);
    logic [BW-1:0] r;
    for (int i = 0; i < BW; i++) r[i] = !(b[i] && (lane ? wwin : 1'b1));
    return r;
  endfunction

  task automatic scramble_cfg();
    c_wr = $urandom; c_wen = $urandom; c_lane = $urandom; c_ext = $urandom; c_adv = $urandom;
  endtask

  task automatic set_cfg(input int b, input int wr, input int wen,
                         input bit lane, input bit ext, input bit adv);
    c_wr[b*4 +: 4] = 4'(wr);
    c_wen[b*4 +: 4] = 4'(wen);
    c_lane[b] = lane; c_ext[b] = ext; c_adv[b] = adv;
  endtask

  task automatic check_idle(input string tag);
    chk(ready == 1'b1, tag, "ready idle", 64'(ready), 1);
    chk(cs_n == '1, tag, "cs idle", 64'(cs_n), 64'hF);
    chk(done == 1'b0, tag, "done idle", 64'(done), 0);
  endtask

  // one write; wpct = wait probability, hold0 = forced wait cycles at tick 0
  task automatic run_write(input int b, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [BW-1:0] bv, input int wr, input int wen,
                           input bit lane, input bit ext, input bit adv,
                           input int wpct, input int hold0, input bit poke);
    int t, last, h;
    bit w, wwin;
    logic [NB-1:0] ecs;
    scramble_cfg();
    set_cfg(b, wr, wen, lane, ext, adv);
    bank = 2'(b); addr = a; wdata = d; be = bv; req = 1'b1; mwait = 1'b0;
    chk(ready == 1'b1, "R1", "ready before accept", 64'(ready), 1);
    @(posedge clk); @(negedge clk);
    scramble_cfg();  // R8: changes after acceptance must not matter
    req = poke;
    if (poke) begin addr = ~a; wdata = ~d; bank = 2'(b + 1); end
    if (wen > wr) begin
      chk(err == 1'b1, "R4", "cfg_err", 64'(err), 1);
      chk(done == 1'b1, "R4", "done on err", 64'(done), 1);
      chk(cs_n == '1 && we_n && bls_n == '1, "R4", "strobes quiet", 64'({cs_n, we_n, bls_n}), 64'h1FF);
      req = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(err == 1'b0, "R4", "err pulse width", 64'(err), 0);
      check_idle("R4");
      return;
    end
    t = 0; last = 2*wr + 2; h = hold0;
    ecs = ~(NB'(1) << b);
    forever begin
      wwin = (t >= 2*wen + 1) && (t <= 2*wr + 1);
      chk(cs_n == ecs, "R2", "cs", 64'(cs_n), 64'(ecs));
      chk(we_n == (lane ? 1'b1 : !wwin), lane ? "R5" : "R3", "we", 64'(we_n), 64'(lane ? 1'b1 : !wwin));
      chk(bls_n == exp_bls(bv, lane, wwin), "R5", "bls", 64'(bls_n), 64'(exp_bls(bv, lane, wwin)));
      chk(adv_n == !(adv && t < 2), "R7", "adv", 64'(adv_n), 64'(!(adv && t < 2)));
      chk(maddr == a && mdata == d, "R8", "addr/data", 64'({maddr, mdata}), 64'({a, d}));
      chk(ready == 1'b0 && done == 1'b0, "R1", "busy", 64'({ready, done}), 0);
      if (t == last) break;
      if (t == 0 && h > 0) begin w = 1'b1; h--; end
      else w = (($urandom % 100) < wpct);
      mwait = w;
      if (!(ext && w)) t++;  // R6
      @(posedge clk); @(negedge clk);
    end
    mwait = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(cs_n == '1, "R9", "cs high after end", 64'(cs_n), 64'hF);
    chk(done == 1'b0, "R9", "done not yet", 64'(done), 0);
    chk(maddr == a && mdata == d, "R8", "hold after cs", 64'({maddr, mdata}), 64'({a, d}));
    @(posedge clk); @(negedge clk);
    chk(done == 1'b1, "R9", "done pulse", 64'(done), 1);
    chk(ready == 1'b0, "R9", "not ready on done", 64'(ready), 0);
    req = 1'b0;
    @(posedge clk); @(negedge clk);
    check_idle("R9");
    @(posedge clk); @(negedge clk);
    chk(cs_n == '1, "R1", "no transfer from busy request", 64'(cs_n), 64'hF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(cs_n == '1 && we_n && adv_n && bls_n == '1, "R2", "reset strobes", 64'({cs_n, we_n, adv_n, bls_n}), 64'h3FF);
    chk(done == 1'b0 && err == 1'b0, "R9", "reset done", 64'({done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
    // directed corners
    run_write(0, 24'h000123, 32'hDEAD_BEEF, 4'hF, 0, 0, 0, 0, 1, 0, 0, 0);   // R2 R3 minimum
    run_write(1, 24'h00ABCD, 32'h1234_5678, 4'hF, 1, 1, 0, 0, 1, 0, 0, 0);   // R3 wr=wen=1
    run_write(2, 24'hFFFFFF, 32'hA5A5_5A5A, 4'hF, 15, 15, 0, 0, 0, 0, 0, 0); // R3 R7 max, adv off
    run_write(3, 24'h800000, 32'h0F0F_0F0F, 4'h5, 15, 0, 0, 0, 1, 0, 0, 1);  // R5 wide lanes, R1 poke
    run_write(0, 24'h000010, 32'h0000_00FF, 4'h1, 3, 2, 1, 0, 1, 0, 0, 0);   // R5 lane mode
    run_write(1, 24'h000020, 32'h0, 4'hF, 2, 3, 0, 0, 1, 0, 0, 0);           // R4 bad config
    run_write(2, 24'h000030, 32'h0, 4'hF, 4, 5, 1, 1, 1, 0, 0, 1);           // R4 with poke
    run_write(3, 24'h000040, 32'hCAFE_F00D, 4'hF, 2, 2, 0, 1, 1, 0, 5, 0);   // R6 hold before strobe
    run_write(0, 24'h000050, 32'hBEEF_0001, 4'hC, 3, 1, 0, 1, 1, 50, 0, 0);  // R6 random waits
    run_write(1, 24'h000060, 32'h7777_7777, 4'hF, 3, 1, 0, 0, 1, 60, 4, 0);  // R6 wait ignored
    // constrained random
    for (int k = 0; k < 40; k++) begin
      int wr_r, wen_r;
      wr_r = $urandom % 16;
      wen_r = (($urandom % 8) == 0) ? (wr_r + 1 + ($urandom % 3)) % 16 : $urandom % (wr_r + 1);
      run_write($urandom % NB, AW'($urandom), $urandom, BW'($urandom), wr_r, wen_r,
                1'($urandom), 1'($urandom), 1'($urandom), $urandom % 40, $urandom % 3, 1'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule